// File: doc/BRIEF.md
# Codec Control Register File

This block holds the 16-bit control and status registers of an audio codec. The serial link receiver hands it one command per cycle: a read or a write, a 7-bit register index that is always even for real registers, and 16 bits of write data. The block answers each read one cycle later with the echoed index and the register value, ready for the link transmitter to put into the next outgoing status frame.

A write of any value to index 00h puts every register back to its default. A read of that index returns a fixed capability code. The powerdown register mixes writable control bits with live ready flags. The extended identity register is read-only and reports variable-rate support and the strapped codec identity. Bit 8 of the general purpose register picks one of the two microphone inputs. A test mode, once entered, is left only through the active-low cold reset.

Top module: `codecRegFile`

## Requirements
- R1: While `rstN` is low and after it rises, every register holds its default, `rdValid` is 0 and `testMode` is 0.
- R2: A read of index 00h returns 0D40h.
- R3: A write of any data to index 00h returns the volume, general purpose and powerdown control registers to their defaults on the next cycle.
- R4: Odd indices and unassigned even indices read 0000h, and writes to them change no register.
- R5: Index 26h reads {control[7:0], 4'b0000, readyIn[3:0]}. Bits 15:8 are writable control bits with default 00h. Bits 3:0 show the live ready inputs as sampled in the read cycle, bit 0 being ADC ready, so 000Fh means every section is ready.
- R6: Index 28h reads {codecId[1:0], 13'b0, 1'b1}, where bit 0 set means variable-rate support and identity 0 is primary while 1 and 2 are secondary. Writes to it have no effect.
- R7: Index 20h is fully writable with default 0000h, and `micSelect` always equals its bit 8.
- R8: A read command accepted at a clock edge gives `rdValid`=1 after that edge, with `rdIndex` equal to the command index and `rdData` holding the value from before any write. A cycle with no read command gives `rdValid`=0.
- R9: A `testEnter` pulse sets `testMode`. Only a cold reset clears it. A write to 00h does not clear it.
- R10: Volume registers at 02h (default 8000h) and 18h (default 8808h) are fully writable and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low cold reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdIndex | input | 7 | Register index |
| cmdWrData | input | 16 | Write data |
| readyIn | input | 4 | Live ready flags of the sections, bit 0 = ADC |
| codecId | input | 2 | Strapped codec identity |
| testEnter | input | 1 | Request to enter test mode |
| rdValid | output | 1 | Read response valid |
| rdIndex | output | 7 | Echoed index of the read |
| rdData | output | 16 | Read data |
| micSelect | output | 1 | Microphone input select |
| testMode | output | 1 | Test mode active |

## Verification
The register space is swept with reads of every implemented index, of an odd index and of an unassigned even index. These reads are made after cold reset, after writes of distinct patterns, and after a reset write to 00h, which separates stored values from defaults and from the zero returned by reserved indices. The powerdown register is read under several ready-input patterns, and the identity register under several strap values, so a swapped or stale bit shows up. Test mode is entered and then followed by a register-reset write and a cold reset, which shows which reset path clears it.

// File: rtl/codecRegPkg.sv
package codecRegPkg;
  localparam int DATA_W  = 16;
  localparam int IDX_W   = 7;
  localparam int RDY_W   = 4;
  localparam int ID_W    = 2;
  localparam int NUM_VOL = 2;
  localparam int VSEL_W  = (NUM_VOL > 1) ? $clog2(NUM_VOL) : 1;
  localparam int PCTL_W  = DATA_W / 2;
  localparam int PPAD_W  = DATA_W - PCTL_W - RDY_W;
  localparam int EPAD_W  = DATA_W - ID_W - 1;

  localparam logic [IDX_W-1:0] IDX_RESET = 7'h00;
  localparam logic [IDX_W-1:0] IDX_GP    = 7'h20;
  localparam logic [IDX_W-1:0] IDX_PWR   = 7'h26;
  localparam logic [IDX_W-1:0] IDX_EXTID = 7'h28;

  localparam logic [IDX_W-1:0]  VOL_IDX [NUM_VOL] = '{7'h02, 7'h18};
  localparam logic [DATA_W-1:0] VOL_DEF [NUM_VOL] = '{16'h8000, 16'h8808};

  localparam logic [DATA_W-1:0] CAP_CODE = 16'h0D40;
  localparam logic [DATA_W-1:0] GP_DEF   = '0;
  localparam logic [PCTL_W-1:0] PCTL_DEF = '0;

  typedef enum logic [2:0] {
    SEL_ZERO, SEL_CAP, SEL_VOL, SEL_GP, SEL_PWR, SEL_EXT
  } rdSel_e;

  typedef struct packed {
    logic               softReset;
    logic [NUM_VOL-1:0] wrVol;
    logic               wrGp;
    logic               wrPwr;
    logic               rdEn;
    rdSel_e             rdSel;
    logic [VSEL_W-1:0]  volSel;
  } strobe_t;
endpackage

// File: rtl/codecRegCtrl.sv
module codecRegCtrl
  import codecRegPkg::*;
(
  input  logic             cmdValid,
  input  logic             cmdRead,
  input  logic [IDX_W-1:0] cmdIndex,
  output strobe_t          stb
);
  logic               isWrite;
  logic [NUM_VOL-1:0] volHit;

  assign isWrite = cmdValid && !cmdRead;

  for (genvar i = 0; i < NUM_VOL; i++) begin : gVolHit
    assign volHit[i] = (cmdIndex == VOL_IDX[i]);
  end

  always_comb begin
    stb           = '0;
    stb.softReset = isWrite && (cmdIndex == IDX_RESET);
    stb.wrVol     = isWrite ? volHit : '0;
    stb.wrGp      = isWrite && (cmdIndex == IDX_GP);
    stb.wrPwr     = isWrite && (cmdIndex == IDX_PWR);
    stb.rdEn      = cmdValid && cmdRead;
    stb.rdSel     = SEL_ZERO;
    for (int i = 0; i < NUM_VOL; i++) begin
      if (volHit[i]) begin
        stb.rdSel  = SEL_VOL;
        stb.volSel = VSEL_W'(i);
      end
    end
    if (cmdIndex == IDX_RESET) stb.rdSel = SEL_CAP;
    if (cmdIndex == IDX_GP)    stb.rdSel = SEL_GP;
    if (cmdIndex == IDX_PWR)   stb.rdSel = SEL_PWR;
    if (cmdIndex == IDX_EXTID) stb.rdSel = SEL_EXT;
  end
endmodule

// File: rtl/codecRegData.sv
module codecRegData
  import codecRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic [RDY_W-1:0]  readyIn,
  input  logic [ID_W-1:0]   codecId,
  input  logic              testEnter,
  output logic              rdValid,
  output logic [IDX_W-1:0]  rdIndex,
  output logic [DATA_W-1:0] rdData,
  output logic              micSelect,
  output logic              testMode
);
  logic [DATA_W-1:0] volReg [NUM_VOL];
  logic [DATA_W-1:0] gpReg;
  logic [PCTL_W-1:0] pwrCtl;
  logic [DATA_W-1:0] rdMux;

  for (genvar i = 0; i < NUM_VOL; i++) begin : gVol
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              volReg[i] <= VOL_DEF[i];
      else if (stb.softReset) volReg[i] <= VOL_DEF[i];
      else if (stb.wrVol[i])  volReg[i] <= cmdWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gpReg  <= GP_DEF;
      pwrCtl <= PCTL_DEF;
    end else if (stb.softReset) begin
      gpReg  <= GP_DEF;
      pwrCtl <= PCTL_DEF;
    end else begin
      if (stb.wrGp)  gpReg  <= cmdWrData;
      if (stb.wrPwr) pwrCtl <= cmdWrData[DATA_W-1 -: PCTL_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          testMode <= 1'b0;
    else if (testEnter) testMode <= 1'b1;
  end

  always_comb begin
    unique case (stb.rdSel)
      SEL_CAP: rdMux = CAP_CODE;
      SEL_VOL: rdMux = volReg[stb.volSel];
      SEL_GP:  rdMux = gpReg;
      SEL_PWR: rdMux = {pwrCtl, {PPAD_W{1'b0}}, readyIn};
      SEL_EXT: rdMux = {codecId, {EPAD_W{1'b0}}, 1'b1};
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdIndex <= '0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) begin
        rdIndex <= cmdIndex;
        rdData  <= rdMux;
      end
    end
  end

  assign micSelect = gpReg[8];
endmodule

// File: rtl/codecRegFile.sv
module codecRegFile
  import codecRegPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdRead,
  input  logic [IDX_W-1:0]  cmdIndex,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic [RDY_W-1:0]  readyIn,
  input  logic [ID_W-1:0]   codecId,
  input  logic              testEnter,
  output logic              rdValid,
  output logic [IDX_W-1:0]  rdIndex,
  output logic [DATA_W-1:0] rdData,
  output logic              micSelect,
  output logic              testMode
);
  strobe_t stb;

  codecRegCtrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdRead  (cmdRead),
    .cmdIndex (cmdIndex),
    .stb      (stb)
  );

  codecRegData u_data (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cmdIndex  (cmdIndex),
    .cmdWrData (cmdWrData),
    .readyIn   (readyIn),
    .codecId   (codecId),
    .testEnter (testEnter),
    .rdValid   (rdValid),
    .rdIndex   (rdIndex),
    .rdData    (rdData),
    .micSelect (micSelect),
    .testMode  (testMode)
  );
endmodule

// File: rtl/codecRegFile_chk.sv
module codecRegFile_chk
  import codecRegPkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cmdValid,
  input logic              cmdRead,
  input logic [IDX_W-1:0]  cmdIndex,
  input logic [DATA_W-1:0] cmdWrData,
  input logic [RDY_W-1:0]  readyIn,
  input logic [ID_W-1:0]   codecId,
  input logic              testEnter,
  input logic              rdValid,
  input logic [IDX_W-1:0]  rdIndex,
  input logic [DATA_W-1:0] rdData,
  input logic              micSelect,
  input logic              testMode
);
  logic rdCmd;
  assign rdCmd = cmdValid && cmdRead;

  a_r8_read_echo: assert property (@(posedge clk) disable iff (!rstN)
    rdCmd |=> rdValid && (rdIndex == $past(cmdIndex)));

  a_r8_no_resp: assert property (@(posedge clk) disable iff (!rstN)
    !rdCmd |=> !rdValid);

  a_r2_cap_code: assert property (@(posedge clk) disable iff (!rstN)
    rdCmd && (cmdIndex == IDX_RESET) |=> rdData == CAP_CODE);

  a_r4_odd_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdCmd && cmdIndex[0] |=> rdData == '0);

  a_r5_ready_live: assert property (@(posedge clk) disable iff (!rstN)
    rdCmd && (cmdIndex == IDX_PWR) |=> rdData[RDY_W-1:0] == $past(readyIn));

  a_r6_ext_id: assert property (@(posedge clk) disable iff (!rstN)
    rdCmd && (cmdIndex == IDX_EXTID) |=>
      rdData == {$past(codecId), {EPAD_W{1'b0}}, 1'b1});

  a_r7_mic_sel: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdRead && (cmdIndex == IDX_GP) |=> micSelect == $past(cmdWrData[8]));

  a_r9_test_sticky: assert property (@(posedge clk) disable iff (!rstN)
    testMode |=> testMode);
endmodule

bind codecRegFile codecRegFile_chk u_chk (.*);

// File: tb/tb_codecRegFile.sv
module tb_codecRegFile;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0, cmdRead = 1'b0, testEnter = 1'b0;
  logic [6:0]  cmdIndex = '0;
  logic [15:0] cmdWrData = '0;
  logic [3:0]  readyIn = '0;
  logic [1:0]  codecId = '0;
  logic        rdValid, micSelect, testMode;
  logic [6:0]  rdIndex;
  logic [15:0] rdData;

  int checks = 0, errors = 0;
  string curReq = "R1";

  logic [15:0] mVol02, mVol18, mGp;
  logic [7:0]  mPwr;
  logic        eValid, eTest;
  logic [6:0]  eIdx;
  logic [15:0] eData;

  always #2.5 clk = ~clk;

  codecRegFile dut (.*);

  function automatic logic [15:0] modelRead(input logic [6:0] idx);
    if (idx[0]) return 16'h0000;
    case (idx)
      7'h00: return 16'h0D40;
      7'h02: return mVol02;
      7'h18: return mVol18;
      7'h20: return mGp;
      7'h26: return {mPwr, 4'h0, readyIn};
      7'h28: return {codecId, 13'h0, 1'b1};
      default: return 16'h0000;
    endcase
  endfunction

  task automatic modelDefaults();
    mVol02 = 16'h8000; mVol18 = 16'h8808; mGp = 16'h0000; mPwr = 8'h00;
  endtask

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modelDefaults();
      eValid = 1'b0; eTest = 1'b0; eIdx = '0; eData = '0;
    end else begin
      eValid = cmdValid && cmdRead;
      if (eValid) begin
        eIdx  = cmdIndex;
        eData = modelRead(cmdIndex);
      end
      if (cmdValid && !cmdRead) begin
        case (cmdIndex)
          7'h00: modelDefaults();
          7'h02: mVol02 = cmdWrData;
          7'h18: mVol18 = cmdWrData;
          7'h20: mGp = cmdWrData;
          7'h26: mPwr = cmdWrData[15:8];
          default: ;
        endcase
      end
      if (testEnter) eTest = 1'b1;
    end
  end

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    check("rdValid", rdValid, eValid);
    if (eValid) begin
      check("rdIndex", rdIndex, eIdx);
      check("rdData", rdData, eData);
    end
    check("micSelect", micSelect, mGp[8]);
    check("testMode", testMode, eTest);
  end

  task automatic idle();
    @(negedge clk); #1;
    cmdValid = 1'b0; cmdRead = 1'b0; testEnter = 1'b0;
  endtask

  task automatic doRead(input logic [6:0] idx);
    @(negedge clk); #1;
    cmdValid = 1'b1; cmdRead = 1'b1; cmdIndex = idx; testEnter = 1'b0;
  endtask

  task automatic doWrite(input logic [6:0] idx, input logic [15:0] d);
    @(negedge clk); #1;
    cmdValid = 1'b1; cmdRead = 1'b0; cmdIndex = idx; cmdWrData = d; testEnter = 1'b0;
  endtask

  task automatic readAll();
    doRead(7'h00); doRead(7'h02); doRead(7'h18); doRead(7'h20);
    doRead(7'h26); doRead(7'h28); doRead(7'h04); doRead(7'h03);
    idle();
  endtask

  initial begin
    fork
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual expired expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none

    curReq = "R1";
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;
    idle();
    curReq = "R1 R2 R4 R10"; readAll();

    curReq = "R10"; doWrite(7'h02, 16'h1234); doWrite(7'h18, 16'hBEEF);
    doRead(7'h02); doRead(7'h18); idle();

    curReq = "R7"; doWrite(7'h20, 16'h0100); idle(); doRead(7'h20);
    doWrite(7'h20, 16'hFEFF); doRead(7'h20); idle();

    curReq = "R4"; doWrite(7'h10, 16'hFFFF); doWrite(7'h03, 16'hFFFF);
    doRead(7'h10); doRead(7'h03); readAll();

    curReq = "R6"; doWrite(7'h28, 16'hFFFE);
    for (int i = 0; i < 4; i++) begin
      codecId = 2'(i); doRead(7'h28);
    end
    idle();

    curReq = "R5"; doWrite(7'h26, 16'hA5FF);
    foreach (readyIn[b]) begin
      readyIn = 4'(1 << b); doRead(7'h26);
    end
    readyIn = 4'hF; doRead(7'h26);
    readyIn = 4'h5; doRead(7'h26);
    readyIn = 4'h0; doRead(7'h26); idle();

    curReq = "R8"; doRead(7'h02); idle(); idle(); doRead(7'h18);

    curReq = "R9"; @(negedge clk); #1 cmdValid = 1'b0; testEnter = 1'b1;
    idle(); idle();

    curReq = "R3 R9"; doWrite(7'h00, 16'h5A5A); readAll();

    curReq = "R1 R9"; doWrite(7'h20, 16'h0100); idle();
    @(negedge clk); #1 rstN = 1'b0;
    @(negedge clk);
    check("R1 testMode in reset", testMode, 1'b0);
    check("R1 rdValid in reset", rdValid, 1'b0);
    #1 rstN = 1'b1;
    readAll();

    idle(); idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule